// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block is the management-bus master that a MAC uses to read and write the registers of an Ethernet PHY. Software loads a 16-bit data register and then a 32-bit command word. The command word holds the PHY address, the PHY register address, a read/write selector, a start/busy flag and a 4-bit code that selects the management clock rate. Setting the busy flag starts one clause-22 frame. The block generates the management clock, shifts the frame out on the data line and, for reads, releases the line and samples the PHY's reply. When the frame is finished it clears the busy flag. Software detects completion by polling that flag.

The management clock is a division of the system clock. The 4-bit code selects a ratio from a fixed, non-linear set. An external enable, which comes from the MAC's own command register, gates the clock. While that enable is low the clock is held low and the frame pauses where it is. The frame continues when the enable returns.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word and the data register read zero, `mdc` is low and `mdioOe` is low.
- R2: The command word reads back its fields in these positions: register address in bits 4:0, PHY address in bits 12:8, write flag in bit 16 (1 = write, 0 = read), busy in bit 17 and divider code in bits 23:20. Every other bit reads zero. The fields do not change while busy is set.
- R3: A command write with bit 17 set starts a frame. Busy then reads 1 for exactly 64 MDC periods and clears itself. `mdc` is low whenever busy is clear.
- R4: Divider codes 0x0 to 0xF give MDC periods of 4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54 and 60 system clocks. The clock is high for half of each period and starts low.
- R5: A write frame, as seen at the MDC rising edges, carries these bits in order: 32 ones, start 01, opcode 01, the PHY address MSB first, the register address MSB first, turnaround 10, then the 16 data bits MSB first. `mdioOut` changes only after a falling edge of MDC.
- R6: A read frame uses opcode 10. `mdioOe` is low from the first turnaround bit to the end of the frame. `mdioOe` is high only while busy is set.
- R7: For a read, `mdioIn` is sampled on the 16 MDC rising edges of the data phase, MSB first. The result is in the data register when busy clears.
- R8: While busy is set, writes to the command word and to the data register are ignored.
- R9: While `mdcEnable` is low, `mdc` stays low and the frame is frozen: busy, `mdioOut` and `mdioOe` keep their values. The frame continues from the same point when the enable returns.
- R10: A command write with bit 17 clear updates the stored fields but does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 data register, 1 command word |
| wrData | input | 32 | Write data |
| cmdRd | output | 32 | Command word read-back |
| dataRd | output | 16 | Data register read-back |
| mdcEnable | input | 1 | Gate for the management clock |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven towards the PHY |
| mdioOe | output | 1 | Output enable for `mdioOut` |
| mdioIn | input | 1 | Serial data from the PHY |

## Verification
The assertions assume that the register port sees known values and that the clock gate is driven synchronously to the system clock. They also assume that any write arriving during a frame is a misuse that the block must absorb. The stimulus applies every input one nanosecond after a rising edge, so no input changes near an edge. The bench's PHY responder drives `mdioIn` only during a read's data phase and holds it at one otherwise, like a pulled-up line. The bench deliberately issues writes during a frame and drops the clock enable in the middle of a read. These cases keep the assertions' disable-free windows non-trivial while staying within those input assumptions.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // Control-to-datapath strobes, one cycle each.
  typedef struct packed {
    logic load;    // latch a new frame
    logic shift;   // advance to the next serial bit
    logic sample;  // capture mdioIn on a rising MDC edge
    logic commit;  // move captured read data to the data register
  } mdioStrobeT;

  // Command word bit positions that the software contract fixes.
  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_WRITE    = 16;
  localparam int CMD_BUSY     = 17;
  localparam int CMD_CODE_LSB = 20;

  // Divider code to MDC period in system clocks (always even).
  function automatic logic [5:0] divRatio(input logic [3:0] code);
    case (code)
      4'h0: divRatio = 6'd4;
      4'h1: divRatio = 6'd6;
      4'h2: divRatio = 6'd8;
      4'h3: divRatio = 6'd12;
      4'h4: divRatio = 6'd16;
      4'h5: divRatio = 6'd20;
      4'h6: divRatio = 6'd24;
      4'h7: divRatio = 6'd28;
      4'h8: divRatio = 6'd30;
      4'h9: divRatio = 6'd32;
      4'hA: divRatio = 6'd36;
      4'hB: divRatio = 6'd40;
      4'hC: divRatio = 6'd44;
      4'hD: divRatio = 6'd48;
      4'hE: divRatio = 6'd54;
      default: divRatio = 6'd60;
    endcase
  endfunction

endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_W     = 5,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  input  logic        mdcEnable,
  output logic [31:0] cmdRd,
  output logic        busy,
  output logic        mdc,
  output logic        driveEn,
  output mdioStrobeT  strobe
);

  localparam int IDX_W    = $clog2(FRAME_LEN);
  localparam int TA_POS   = FRAME_LEN - DATA_W - 2;
  localparam int DATA_POS = FRAME_LEN - DATA_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             busyQ, writeQ, mdcQ;
  logic [PHY_W-1:0] phyQ;
  logic [REG_W-1:0] regQ;
  logic [3:0]       codeQ;
  logic [4:0]       halfCnt, halfLim;
  logic [IDX_W-1:0] bitIdx;
  logic             cmdAcc, start, tick, rise, fall, last;
  logic [31:0]      wrDataUnused;

  assign wrDataUnused = wrData;

  assign halfLim = 5'(divRatio(codeQ) >> 1) - 5'd1;
  assign cmdAcc  = wrEn & wrSel & ~busyQ;
  assign start   = cmdAcc & wrData[CMD_BUSY];
  assign tick    = busyQ & mdcEnable & (halfCnt == halfLim);
  assign rise    = tick & ~mdcQ;
  assign fall    = tick & mdcQ;
  assign last    = (bitIdx == LAST_IDX);

  always_comb begin
    strobe.load   = start;
    strobe.shift  = fall & ~last;
    strobe.sample = rise & ~writeQ & (bitIdx >= IDX_W'(DATA_POS));
    strobe.commit = fall & last & ~writeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      writeQ  <= 1'b0;
      mdcQ    <= 1'b0;
      phyQ    <= '0;
      regQ    <= '0;
      codeQ   <= '0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (cmdAcc) begin
        writeQ <= wrData[CMD_WRITE];
        phyQ   <= wrData[CMD_PHY_LSB +: PHY_W];
        regQ   <= wrData[0 +: REG_W];
        codeQ  <= wrData[CMD_CODE_LSB +: 4];
      end
      if (start) begin
        busyQ   <= 1'b1;
        mdcQ    <= 1'b0;
        halfCnt <= '0;
        bitIdx  <= '0;
      end else if (busyQ && mdcEnable) begin
        halfCnt <= tick ? 5'd0 : halfCnt + 5'd1;
        if (tick) begin
          if (fall && last) begin
            busyQ <= 1'b0;
            mdcQ  <= 1'b0;
          end else begin
            mdcQ <= ~mdcQ;
          end
          if (fall && !last) bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  assign busy    = busyQ;
  assign mdc     = mdcQ & mdcEnable;
  assign driveEn = busyQ & (writeQ | (bitIdx < IDX_W'(TA_POS)));

  always_comb begin
    cmdRd = '0;
    cmdRd[0 +: REG_W]             = regQ;
    cmdRd[CMD_PHY_LSB +: PHY_W]   = phyQ;
    cmdRd[CMD_WRITE]              = writeQ;
    cmdRd[CMD_BUSY]               = busyQ;
    cmdRd[CMD_CODE_LSB +: 4]      = codeQ;
  end

endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobeT        strobe,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic              busy,
  input  logic [31:0]       wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] dataRd
);

  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;

  logic [FRAME_LEN-1:0] frameQ, frameNext;
  logic [DATA_W-1:0]    capQ, dataQ;
  logic [1:0]           opCode;
  logic [31:0]          wrDataUnused;

  assign wrDataUnused = wrData;
  assign opCode = wrData[CMD_WRITE] ? 2'b01 : 2'b10;
  assign frameNext = {{PRE_LEN{1'b1}}, 2'b01, opCode,
                      wrData[CMD_PHY_LSB +: PHY_W], wrData[0 +: REG_W],
                      2'b10, dataQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '0;
      capQ   <= '0;
      dataQ  <= '0;
    end else begin
      if (strobe.load)       frameQ <= frameNext;
      else if (strobe.shift) frameQ <= {frameQ[FRAME_LEN-2:0], 1'b0};
      if (strobe.sample) capQ <= {capQ[DATA_W-2:0], mdioIn};
      if (strobe.commit)                 dataQ <= capQ;
      else if (wrEn && !wrSel && !busy)  dataQ <= wrData[DATA_W-1:0];
    end
  end

  assign mdioOut = frameQ[FRAME_LEN-1];
  assign dataRd  = dataQ;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [31:0]       wrData,
  output logic [31:0]       cmdRd,
  output logic [DATA_W-1:0] dataRd,
  input  logic              mdcEnable,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;

  mdioStrobeT strobe;
  logic       busy;

  mdio_mgmt_ctrl #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .mdcEnable(mdcEnable), .cmdRd(cmdRd), .busy(busy), .mdc(mdc),
    .driveEn(mdioOe), .strobe(strobe)
  );

  mdio_mgmt_datapath #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrSel(wrSel),
    .busy(busy), .wrData(wrData), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .dataRd(dataRd)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrSel,
  input logic              mdcEnable,
  input logic [31:0]       cmdRd,
  input logic [DATA_W-1:0] dataRd,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe
);

  logic busyBit;
  assign busyBit = cmdRd[17];

  assert_mdc_low_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busyBit |-> !mdc);

  assert_release_needs_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busyBit);

  assert_pause_freezes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyBit && !mdcEnable) |=> ($stable(mdioOut) && $stable(mdioOe) && $stable(cmdRd)));

  assert_data_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busyBit && wrEn && !wrSel) |=> ($stable(dataRd) || !busyBit));

  assert_fields_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyBit |=> ($stable(cmdRd[16:0]) && $stable(cmdRd[31:18])));

  assert_mdc_high_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mdc) && mdcEnable) |=> (mdc || !mdcEnable));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .mdcEnable(mdcEnable),
  .cmdRd(cmdRd), .dataRd(dataRd), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        mdcEnable = 1'b1;
  logic        mdioIn = 1'b1;
  logic [31:0] cmdRd;
  logic [15:0] dataRd;
  logic        mdc, mdioOut, mdioOe;

  always #2.5 clk = ~clk;

  mdio_mgmt_master u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cmdRd(cmdRd), .dataRd(dataRd), .mdcEnable(mdcEnable), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ratioTab [16] = '{4, 6, 8, 12, 16, 20, 24, 28, 30, 32, 36, 40, 44, 48, 54, 60};

  // ---------------- behavioural reference model ----------------
  bit          mBusy, mMdc, mWr;
  int          mCnt, mBit;
  logic [4:0]  mPhy, mReg;
  logic [3:0]  mCode;
  logic [15:0] mData, mCap;
  logic [63:0] mFrame;
  logic [15:0] phyVal = 16'h0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mMdc = 0; mWr = 0; mCnt = 0; mBit = 0;
      mPhy = 0; mReg = 0; mCode = 0; mData = 0; mCap = 0; mFrame = 0;
    end else begin
      bit wasBusy;
      wasBusy = mBusy;
      if (mBusy && mdcEnable) begin
        bit tk;
        tk = (mCnt == ratioTab[mCode] / 2 - 1);
        mCnt = tk ? 0 : mCnt + 1;
        if (tk) begin
          if (!mMdc) begin
            if (!mWr && mBit >= 48) mCap = {mCap[14:0], mdioIn};
            mMdc = 1;
          end else begin
            mMdc = 0;
            if (mBit == 63) begin
              mBusy = 0;
              if (!mWr) mData = mCap;
            end else mBit++;
          end
        end
      end
      if (wrEn && !wasBusy) begin
        if (!wrSel) mData = wrData[15:0];
        else begin
          mWr = wrData[16]; mPhy = wrData[12:8]; mReg = wrData[4:0];
          mCode = wrData[23:20];
          if (wrData[17]) begin
            mBusy = 1; mMdc = 0; mCnt = 0; mBit = 0;
            mFrame = {32'hFFFF_FFFF, 2'b01, (wrData[16] ? 2'b01 : 2'b10),
                      wrData[12:8], wrData[4:0], 2'b10, mData};
          end
        end
      end
    end
  end

  // PHY responder: drives reply bits during a read's data phase.
  always @(negedge clk)
    mdioIn = (mBusy && !mWr && mBit >= 48) ? phyVal[63 - mBit] : 1'b1;

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN) begin
      bit expOe;
      logic [31:0] expCmd;
      expOe  = mBusy && (mWr || mBit < 46);
      expCmd = {8'h0, mCode, 2'b00, mBusy, mWr, 3'b000, mPhy, 3'b000, mReg};
      checks++;
      if (mdc !== (mMdc && mdcEnable)) begin
        errors++; $display("FAIL R4 mdc act=%0b exp=%0b t=%0t", mdc, mMdc && mdcEnable, $time);
      end else if (mdioOe !== expOe) begin
        errors++; $display("FAIL R6 mdioOe act=%0b exp=%0b t=%0t", mdioOe, expOe, $time);
      end else if (expOe && mdioOut !== mFrame[63 - mBit]) begin
        errors++; $display("FAIL R5 mdioOut act=%0b exp=%0b t=%0t", mdioOut, mFrame[63 - mBit], $time);
      end else if (cmdRd !== expCmd) begin
        errors++; $display("FAIL R2 cmdRd act=%h exp=%h t=%0t", cmdRd, expCmd, $time);
      end else if (dataRd !== mData) begin
        errors++; $display("FAIL R7 dataRd act=%h exp=%h t=%0t", dataRd, mData, $time);
      end
    end
  end

  // Serial stream and MDC period observed at the pins.
  logic [63:0] streamBits, oeBits;
  int prevMdc = 0, sinceRise = 0, lastPeriod = 0, busyCycles = 0;
  always @(negedge clk) begin
    sinceRise++;
    if (mdc && prevMdc == 0) begin
      streamBits = {streamBits[62:0], mdioOut};
      oeBits     = {oeBits[62:0], mdioOe};
      lastPeriod = sinceRise;
      sinceRise  = 0;
    end
    prevMdc = mdc;
    if (cmdRd[17]) busyCycles++;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic startTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [3:0] code, input logic [15:0] d);
    if (wr) regWrite(1'b0, {16'h0, d});
    busyCycles = 0;
    regWrite(1'b1, {8'h0, code, 2'b00, 1'b1, wr, 3'b000, phy, 3'b000, rg});
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && cmdRd[17]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cmdRd == 0 && dataRd == 0 && !mdc && !mdioOe, "R1 reset state",
          {cmdRd, dataRd, 14'b0, mdc, mdioOe}, 64'h0);

    // R10 + R2: command without start bit, stray bits read as zero
    regWrite(1'b1, 32'hFF2C_F5F5);
    repeat (20) @(negedge clk);
    check(cmdRd == 32'h0020_1515, "R2 field readback", cmdRd, 32'h0020_1515);
    check(!cmdRd[17] && !mdc && !mdioOe, "R10 no start", {mdc, mdioOe}, 0);

    // R5/R3/R4: write frame at the fastest ratio
    startTxn(1'b1, 5'h05, 5'h1A, 4'h0, 16'hBEEF);
    waitIdle();
    check(streamBits == expFrame(1, 5'h05, 5'h1A, 16'hBEEF), "R5 write stream",
          streamBits, expFrame(1, 5'h05, 5'h1A, 16'hBEEF));
    check(busyCycles == 64 * 4, "R3 busy duration", busyCycles, 64 * 4);
    check(lastPeriod == 4, "R4 period code0", lastPeriod, 4);

    // R6/R7: read frame, code 3
    phyVal = 16'hA5C3;
    startTxn(1'b0, 5'h11, 5'h03, 4'h3, 16'h0);
    waitIdle();
    check(streamBits[63:18] == expFrame(0, 5'h11, 5'h03, 16'h0) >> 18, "R6 read header",
          streamBits[63:18], expFrame(0, 5'h11, 5'h03, 16'h0) >> 18);
    check(oeBits == {{46{1'b1}}, 18'h0}, "R6 release window", oeBits, {{46{1'b1}}, 18'h0});
    check(dataRd == 16'hA5C3, "R7 read data", dataRd, 16'hA5C3);
    check(busyCycles == 64 * 12, "R3 busy duration code3", busyCycles, 64 * 12);

    // R8: writes during a frame are ignored
    startTxn(1'b1, 5'h1F, 5'h00, 4'hE, 16'h5A5A);
    repeat (100) @(negedge clk);
    regWrite(1'b0, 32'h0000_1234);
    regWrite(1'b1, 32'h00F3_1F1F);
    waitIdle();
    check(dataRd == 16'h5A5A, "R8 data kept", dataRd, 16'h5A5A);
    check(cmdRd == 32'h00E1_1F00, "R8 command kept", cmdRd, 32'h00E1_1F00);
    check(lastPeriod == 54, "R4 period codeE", lastPeriod, 54);

    // R9: pause a read mid-frame
    phyVal = 16'h3C96;
    startTxn(1'b0, 5'h02, 5'h1E, 4'h8, 16'h0);
    repeat (300) @(negedge clk);
    @(posedge clk); #1 mdcEnable = 1'b0;
    for (int i = 0; i < 77; i++) begin
      @(negedge clk);
      check(!mdc && cmdRd[17], "R9 paused", {mdc, cmdRd[17]}, 2'b01);
    end
    @(posedge clk); #1 mdcEnable = 1'b1;
    waitIdle();
    check(dataRd == 16'h3C96, "R9 R7 data after pause", dataRd, 16'h3C96);
    check(busyCycles == 64 * 30 + 77, "R9 busy stretched", busyCycles, 64 * 30 + 77);

    // R4: every divider code
    for (int c = 0; c < 16; c++) begin
      logic [15:0] d;
      d = 16'h1000 * c + 16'h0F0F;
      startTxn(1'b1, 5'(c), 5'(~c), 4'(c), d);
      waitIdle();
      check(lastPeriod == ratioTab[c], "R4 period", lastPeriod, ratioTab[c]);
      check(streamBits == expFrame(1, 5'(c), 5'(~c), d), "R5 stream per code",
            streamBits, expFrame(1, 5'(c), 5'(~c), d));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule